// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Command Register Bank

This block sits behind a serial receiver and takes one committed 24-bit command word per cycle when `cmdValid` is high. It keeps, for each of two output channels, a staging buffer and an active register pair holding a 16-bit code and a 2-bit power mode. The upper byte of each command says which staging buffer receives the word and which channels copy their staging buffer into the active registers. A staged entry holds either a data value or a power-down request.

A command can write one buffer and load one channel, both channels or neither. Because of this, an analog stage can be moved one channel at a time or both at the same moment. A load copies the staging content as it stands after that same command has written it. Each channel has a one-cycle update pulse that marks every write to its active registers. The serial framing and the analog output stage are outside this block.

Top module: `dual_cmd_bank`

## Requirements
- R1: While `rstN` is low and after it is released, both active codes are 0, both active modes are 00 (normal), both staging buffers hold code 0 in mode 00, and no update pulse is raised.
- R2: An accepted command with bits 21 and 20 both clear changes only a staging buffer. Both active codes and modes stay unchanged and no update pulse fires.
- R3: Bit 20 loads channel A and bit 21 loads channel B. A loaded channel takes its staging content, including anything the same command wrote into it, and the new value is visible on the outputs the cycle after the command.
- R4: With bits 21 and 20 both set, both channels update in the same cycle and both update pulses are high together.
- R5: Bit 18 picks the staging buffer that a command writes: 0 selects channel A and 1 selects channel B. The other buffer is left as it was.
- R6: When bits 17:16 are nonzero, the staged entry is a power-down request. Loading it sets the channel's active mode to that value and leaves the active code as it was, so the staged data word is ignored.
- R7: The active mode encoding is 00 normal, 01 output tied low through about 1 kilohm, 10 tied low through about 100 kilohm, and 11 high impedance. Each value loaded appears unchanged on the mode output.
- R8: A powered-down channel returns to normal only when its buffer receives mode 00 with new data and is then loaded. Reloading a buffer that still holds a power-down request keeps the channel powered down, and writing mode 00 without a load does not change it either.
- R9: A command whose bits 23:22 are not both zero is ignored completely. No buffer, active register or pulse changes.
- R10: A channel's update pulse is high for exactly the one cycle after each command that loads that channel, even when the value does not change. It stays low after all other cycles.
- R11: Bit 19 has no effect on any output or buffer.
- R12: While `cmdValid` is low, the command word is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command commit strobe, one word per high cycle |
| cmdWord | input | 24 | Command word: control byte in bits 23:16, data in bits 15:0 |
| codeA | output | 16 | Active code of channel A |
| modeA | output | 2 | Active power mode of channel A |
| updA | output | 1 | One-cycle pulse when channel A's active registers are written |
| codeB | output | 16 | Active code of channel B |
| modeB | output | 2 | Active power mode of channel B |
| updB | output | 1 | One-cycle pulse when channel B's active registers are written |

## Verification
The staging buffers cannot be read directly, so their contents have to be inferred. The hardest case is proving that a rejected command or a stale power-down request left a buffer unchanged. The stimulus does this by sending a command that writes the other channel's buffer while loading the channel under test, which exposes the untouched staging content on the active outputs. A sweep over all 256 control bytes, driven against an arithmetic model of buffers and active registers, covers every combination of select, load, mode and reserved bits in turn.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  parameter int CODE_W = 16;
  parameter int MODE_W = 2;
  parameter int CH_N   = 2;

  localparam int WORD_W   = CODE_W + 8;
  localparam int MODE_LO  = CODE_W;
  localparam int SEL_BIT  = CODE_W + 2;
  localparam int DC_BIT   = CODE_W + 3;
  localparam int LOAD_LO  = CODE_W + 4;
  localparam int RSV_LO   = CODE_W + 6;
  localparam int RSV_HI   = WORD_W - 1;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t MODE_NORMAL = '0;

  // strobes from decode to the register datapath
  typedef struct packed {
    logic [CH_N-1:0] bufWr;
    logic [CH_N-1:0] chLoad;
  } dcb_strobe_t;
endpackage

// File: rtl/dcb_ctrl.sv
module dcb_ctrl
  import dcb_pkg::*;
(
  input  logic              cmdValid,
  input  logic [WORD_W-1:0] cmdWord,
  output dcb_strobe_t       stb,
  output code_t             stageCode,
  output mode_t             stageMode
);
  logic accept;
  logic unusedDontCare;

  assign unusedDontCare = cmdWord[DC_BIT];
  assign accept    = cmdValid && (cmdWord[RSV_HI:RSV_LO] == '0);
  assign stageCode = cmdWord[CODE_W-1:0];
  assign stageMode = cmdWord[MODE_LO +: MODE_W];

  always_comb begin
    stb = '0;
    for (int i = 0; i < CH_N; i++) begin
      stb.bufWr[i]  = accept && (cmdWord[SEL_BIT] == i[0]);
      stb.chLoad[i] = accept && cmdWord[LOAD_LO + i];
    end
  end
endmodule

// File: rtl/dcb_datapath.sv
module dcb_datapath
  import dcb_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  dcb_strobe_t                  stb,
  input  code_t                        stageCode,
  input  mode_t                        stageMode,
  output logic [CH_N-1:0][CODE_W-1:0]  actCode,
  output logic [CH_N-1:0][MODE_W-1:0]  actMode,
  output logic [CH_N-1:0]              upd
);
  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    code_t bufCode, nxtCode;
    mode_t bufMode, nxtMode;

    // a load in the same commit sees the freshly written staging content
    assign nxtCode = stb.bufWr[ch] ? stageCode : bufCode;
    assign nxtMode = stb.bufWr[ch] ? stageMode : bufMode;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufCode     <= '0;
        bufMode     <= MODE_NORMAL;
        actCode[ch] <= '0;
        actMode[ch] <= MODE_NORMAL;
        upd[ch]     <= 1'b0;
      end else begin
        upd[ch] <= stb.chLoad[ch];
        if (stb.bufWr[ch]) begin
          bufCode <= nxtCode;
          bufMode <= nxtMode;
        end
        if (stb.chLoad[ch]) begin
          actMode[ch] <= nxtMode;
          if (nxtMode == MODE_NORMAL) actCode[ch] <= nxtCode;
        end
      end
    end
  end
endmodule

// File: rtl/dual_cmd_bank.sv
module dual_cmd_bank
  import dcb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [WORD_W-1:0] cmdWord,
  output logic [CODE_W-1:0] codeA,
  output logic [MODE_W-1:0] modeA,
  output logic              updA,
  output logic [CODE_W-1:0] codeB,
  output logic [MODE_W-1:0] modeB,
  output logic              updB
);
  dcb_strobe_t                 stb;
  code_t                       stageCode;
  mode_t                       stageMode;
  logic [CH_N-1:0][CODE_W-1:0] actCode;
  logic [CH_N-1:0][MODE_W-1:0] actMode;
  logic [CH_N-1:0]             upd;

  dcb_ctrl ctrl_i (
    .cmdValid (cmdValid),
    .cmdWord  (cmdWord),
    .stb      (stb),
    .stageCode(stageCode),
    .stageMode(stageMode)
  );

  dcb_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .stageCode(stageCode),
    .stageMode(stageMode),
    .actCode  (actCode),
    .actMode  (actMode),
    .upd      (upd)
  );

  assign codeA = actCode[0];
  assign modeA = actMode[0];
  assign updA  = upd[0];
  assign codeB = actCode[1];
  assign modeB = actMode[1];
  assign updB  = upd[1];
endmodule

// File: rtl/dcb_checker.sv
module dcb_checker
  import dcb_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [WORD_W-1:0] cmdWord,
  input logic [CODE_W-1:0] codeA,
  input logic [MODE_W-1:0] modeA,
  input logic              updA,
  input logic [CODE_W-1:0] codeB,
  input logic [MODE_W-1:0] modeB,
  input logic              updB
);
  logic cmdOk;
  assign cmdOk = cmdValid && (cmdWord[RSV_HI:RSV_LO] == '0);

  a_r1_reset_zero: assert property (@(posedge clk)
    !rstN |=> (codeA == '0 && codeB == '0 && modeA == '0 && modeB == '0 && !updA && !updB));

  a_r2_quiet_a_stable: assert property (@(posedge clk) disable iff (!rstN)
    !updA |-> ($stable(codeA) && $stable(modeA)));

  a_r2_quiet_b_stable: assert property (@(posedge clk) disable iff (!rstN)
    !updB |-> ($stable(codeB) && $stable(modeB)));

  a_r3_load_a_pulses: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOk && cmdWord[LOAD_LO]) |=> updA);

  a_r3_load_b_pulses: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOk && cmdWord[LOAD_LO+1]) |=> updB);

  a_r6_pd_keeps_code_a: assert property (@(posedge clk) disable iff (!rstN)
    (updA && modeA != '0) |-> $stable(codeA));

  a_r6_pd_keeps_code_b: assert property (@(posedge clk) disable iff (!rstN)
    (updB && modeB != '0) |-> $stable(codeB));

  a_r9_reserved_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdWord[RSV_HI:RSV_LO] != '0) |=> (!updA && !updB));

  a_r12_idle_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> (!updA && !updB));
endmodule

bind dual_cmd_bank dcb_checker chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .cmdValid(cmdValid),
  .cmdWord (cmdWord),
  .codeA   (codeA),
  .modeA   (modeA),
  .updA    (updA),
  .codeB   (codeB),
  .modeB   (modeB),
  .updB    (updB)
);

// File: tb/dual_cmd_bank_tb_top.sv
`timescale 1ns/1ps
module dual_cmd_bank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [23:0] cmdWord = '0;
  logic [15:0] codeA, codeB;
  logic [1:0]  modeA, modeB;
  logic        updA, updB;

  int tests = 0;
  int fails = 0;

  logic [15:0] mBufCode [2];
  logic [1:0]  mBufMode [2];
  logic [15:0] mActCode [2];
  logic [1:0]  mActMode [2];
  logic        mUpd     [2];

  always #4 clk = ~clk;

  dual_cmd_bank dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .codeA(codeA), .modeA(modeA), .updA(updA),
    .codeB(codeB), .modeB(modeB), .updB(updB)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic checkAll(input string req);
    chk(req, "codeA", 32'(codeA), 32'(mActCode[0]));
    chk(req, "modeA", 32'(modeA), 32'(mActMode[0]));
    chk(req, "updA",  32'(updA),  32'(mUpd[0]));
    chk(req, "codeB", 32'(codeB), 32'(mActCode[1]));
    chk(req, "modeB", 32'(modeB), 32'(mActMode[1]));
    chk(req, "updB",  32'(updB),  32'(mUpd[1]));
  endtask

  task automatic modelReset();
    for (int c = 0; c < 2; c++) begin
      mBufCode[c] = '0; mBufMode[c] = '0;
      mActCode[c] = '0; mActMode[c] = '0; mUpd[c] = 1'b0;
    end
  endtask

  // drive at a falling edge, let one rising edge act, sample at the next falling edge
  task automatic apply(input logic [23:0] w, input logic v);
    int s;
    mUpd[0] = 1'b0; mUpd[1] = 1'b0;
    if (v && w[23:22] == 2'b00) begin
      s = int'(w[18]);
      mBufMode[s] = w[17:16];
      mBufCode[s] = w[15:0];
      for (int c = 0; c < 2; c++) begin
        if (w[20+c]) begin
          mActMode[c] = mBufMode[c];
          if (mBufMode[c] == 2'b00) mActCode[c] = mBufCode[c];
          mUpd[c] = 1'b1;
        end
      end
    end
    cmdValid = v;
    cmdWord  = w;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    modelReset();
    repeat (5) @(negedge clk);
    checkAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    apply({8'h00, 16'h1234}, 1'b1); checkAll("R2");
    apply({8'h14, 16'hBEEF}, 1'b1); checkAll("R5");        // writes B, loads A from buffer A
    chk("R3", "codeA", 32'(codeA), 32'h1234);
    apply({8'h20, 16'h0001}, 1'b1); checkAll("R5");        // writes A, loads B
    chk("R5", "codeB", 32'(codeB), 32'hBEEF);
    apply({8'h30, 16'hCAFE}, 1'b1); checkAll("R4");
    chk("R4", "both pulses", 32'({updA, updB}), 32'h3);
    apply({8'h30, 16'hCAFE}, 1'b1); checkAll("R10");       // same value again still pulses
    apply({8'h11, 16'h7777}, 1'b1); checkAll("R6");
    chk("R6", "codeA held", 32'(codeA), 32'hCAFE);
    chk("R7", "modeA", 32'(modeA), 32'h1);
    apply({8'h26, 16'h1111}, 1'b1); checkAll("R7");
    chk("R7", "modeB", 32'(modeB), 32'h2);
    apply({8'h37, 16'h2222}, 1'b1); checkAll("R8");        // A reloads stale request
    chk("R8", "modeA stale", 32'(modeA), 32'h1);
    chk("R7", "modeB hi-z", 32'(modeB), 32'h3);
    apply({8'h00, 16'h4444}, 1'b1); checkAll("R8");
    chk("R8", "modeA no load", 32'(modeA), 32'h1);
    apply({8'h14, 16'h0000}, 1'b1); checkAll("R8");
    chk("R8", "codeA exit", 32'(codeA), 32'h4444);
    chk("R8", "modeA exit", 32'(modeA), 32'h0);
    apply({8'h50, 16'h9999}, 1'b1); checkAll("R9");
    apply({8'h80, 16'h8888}, 1'b1); checkAll("R9");
    apply({8'h14, 16'h2222}, 1'b1); checkAll("R9");        // exposes untouched buffer A
    chk("R9", "codeA", 32'(codeA), 32'h4444);
    apply({8'h18, 16'h5555}, 1'b1); checkAll("R11");
    chk("R11", "codeA", 32'(codeA), 32'h5555);
    apply({8'h3F, 16'hFFFF}, 1'b0); checkAll("R12");
    @(negedge clk); checkAll("R10");

    for (int ctl = 0; ctl < 256; ctl++) begin
      apply({ctl[7:0], (16'(ctl) * 16'd257) ^ 16'h5A3C}, 1'b1);
      checkAll("R3");
    end
    for (int ctl = 255; ctl >= 0; ctl--) begin
      apply({ctl[7:0], 16'(ctl) * 16'd73}, 1'b1);
      checkAll("R6");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule